// File: doc/BRIEF.md
# Clock Continuity Error Monitor

This block decides whether the four audio clocks around a sample rate converter are still running at the rate the converter was set up for. It watches the incoming frame and bit clocks, and, when the output port is clocked from outside, the outgoing frame and bit clocks. Each clock passes through a two-flop synchronizer into a free-running system clock domain. Its rising edges are counted over an observation window of fixed length. At the end of each window the count is compared with an expected value, and up to one edge of slip either way is accepted.

The input side uses a long window, a few hundred output frames. The output side uses a short window of a few output frames. An input clock that stops is therefore reported after milliseconds, and a stopped output clock after tens of microseconds. Each side registers its verdict once per window. The error flag clears by the same mechanism it sets, one good window after the clocks recover, and the rest of the system keeps running while the flag is high. Driving the active-low reset is the only way to restart conversion. While reset is held, the block asserts a hold on the serial data outputs. In master mode it also asserts a hold on the locally generated output clocks.

Top module: `clkcont_monitor`

## Requirements
- R1: While `rst_n` is low, `error` is 0 and `data_hold` is 1. Once `rst_n` is high, `data_hold` is 0.
- R2: `clk_hold` is 1 only while `rst_n` is low and `slave` is 0 (master mode). In every other case it is 0.
- R3: If either incoming clock (`in_lr` or `in_bit`) stops, `error` rises within two input windows (2×`IN_WIN` system clocks plus synchronizer latency). This holds in both modes.
- R4: With `slave` = 1, if either outgoing clock (`out_lr` or `out_bit`) stops, `error` rises within two output windows (2×`OUT_WIN` system clocks plus synchronizer latency).
- R5: With `slave` = 0, a stopped outgoing clock has no effect, and `error` stays 0.
- R6: A window is in error when its rising-edge count differs from the expected count by 2 or more. A difference of exactly 1 is accepted.
- R7: After all clocks run correctly again, `error` returns to 0 within two windows of the side that was in error.
- R8: Counting system clock edges from reset release, `error` changes only on an edge whose count is a multiple of `OUT_WIN` or of `IN_WIN`, or in the cycle where `slave` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_clk | input | 1 | Free-running system clock that times the windows |
| in_lr | input | 1 | Incoming frame clock |
| in_bit | input | 1 | Incoming bit clock |
| out_lr | input | 1 | Outgoing frame clock, checked in slave mode |
| out_bit | input | 1 | Outgoing bit clock, checked in slave mode |
| slave | input | 1 | 1: output clocks come from outside and are checked; 0: master mode |
| exp_in_lr | input | CNT_W | Expected incoming frame edges per input window |
| exp_in_bit | input | CNT_W | Expected incoming bit edges per input window |
| exp_out_lr | input | CNT_W | Expected outgoing frame edges per output window |
| exp_out_bit | input | CNT_W | Expected outgoing bit edges per output window |
| error | output | 1 | Clock continuity error flag |
| data_hold | output | 1 | Forces serial data outputs low during reset |
| clk_hold | output | 1 | Forces generated output clocks low during reset in master mode |

## Verification
On every cycle, the assertions check the reset-time values of the flag and the two hold outputs, and that clock holding happens only in master mode during reset. They also use counters of their own to check that the flag moves only on a window boundary or a mode change. Only the bench scenarios can show the timing behaviour. These cover the rise latency after each clock is stopped, the faster response of the output side, that outgoing clocks are ignored in master mode, the one-edge tolerance at both ends, and the clear-down after restart.

// File: rtl/clkcont_monitor.sv
module clkcont_monitor #(
  parameter int IN_WIN  = 131072,
  parameter int OUT_WIN = 2048,
  parameter int CNT_W   = 16
) (
  input  logic             rst_n,
  input  logic             sys_clk,
  input  logic             in_lr,
  input  logic             in_bit,
  input  logic             out_lr,
  input  logic             out_bit,
  input  logic             slave,
  input  logic [CNT_W-1:0] exp_in_lr,
  input  logic [CNT_W-1:0] exp_in_bit,
  input  logic [CNT_W-1:0] exp_out_lr,
  input  logic [CNT_W-1:0] exp_out_bit,
  output logic             error,
  output logic             data_hold,
  output logic             clk_hold
);
  localparam int IT_W = $clog2(IN_WIN);
  localparam int OT_W = $clog2(OUT_WIN);
  localparam int W1   = CNT_W + 1;

  logic [3:0] sy1, sy2, sy3;
  wire  [3:0] raw  = {out_bit, out_lr, in_bit, in_lr};
  wire  [3:0] rise = sy2 & ~sy3;
  wire  [3:0][CNT_W-1:0] expv = {exp_out_bit, exp_out_lr, exp_in_bit, exp_in_lr};

  always_ff @(posedge sys_clk or negedge rst_n)
    if (!rst_n) {sy1, sy2, sy3} <= '0;
    else begin
      sy1 <= raw;
      sy2 <= sy1;
      sy3 <= sy2;
    end

  logic [IT_W-1:0] itmr;
  logic [OT_W-1:0] otmr;
  wire in_end  = (itmr == IT_W'(IN_WIN - 1));
  wire out_end = (otmr == OT_W'(OUT_WIN - 1));

  always_ff @(posedge sys_clk or negedge rst_n)
    if (!rst_n) begin
      itmr <= '0;
      otmr <= '0;
    end else begin
      itmr <= in_end  ? '0 : itmr + 1'b1;
      otmr <= out_end ? '0 : otmr + 1'b1;
    end

  logic [3:0][CNT_W-1:0] cnt;
  logic [3:0]            bad;

  always_ff @(posedge sys_clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else
      for (int i = 0; i < 4; i++)
        cnt[i] <= ((i < 2) ? in_end : out_end) ? '0 : cnt[i] + CNT_W'(rise[i]);

  always_comb
    for (int i = 0; i < 4; i++) begin
      automatic logic [W1-1:0] got = {1'b0, cnt[i] + CNT_W'(rise[i])};
      automatic logic [W1-1:0] want = {1'b0, expv[i]};
      bad[i] = (got > want + W1'(1)) || (got + W1'(1) < want);
    end

  logic err_in, err_out;

  always_ff @(posedge sys_clk or negedge rst_n)
    if (!rst_n) begin
      err_in  <= 1'b0;
      err_out <= 1'b0;
    end else begin
      if (in_end) err_in <= bad[0] | bad[1];
      if (!slave) err_out <= 1'b0;
      else if (out_end) err_out <= bad[2] | bad[3];
    end

  assign error     = err_in | (slave & err_out);
  assign data_hold = ~rst_n;
  assign clk_hold  = ~rst_n & ~slave;
endmodule

// File: rtl/clkcont_monitor_chk.sv
module clkcont_monitor_chk #(
  parameter int IN_WIN  = 131072,
  parameter int OUT_WIN = 2048
) (
  input logic sys_clk,
  input logic rst_n,
  input logic slave,
  input logic error,
  input logic data_hold,
  input logic clk_hold
);
  int icnt, ocnt;

  always_ff @(posedge sys_clk or negedge rst_n)
    if (!rst_n) begin
      icnt <= 0;
      ocnt <= 0;
    end else begin
      icnt <= (icnt == IN_WIN - 1)  ? 0 : icnt + 1;
      ocnt <= (ocnt == OUT_WIN - 1) ? 0 : ocnt + 1;
    end

  always @(posedge sys_clk) begin
    if (!rst_n) assert_reset_quiet_R1: assert (data_hold && !error);
    assert_clk_hold_master_R2: assert (!clk_hold || (!slave && data_hold));
  end

  assert_hold_release_R1: assert property (@(posedge sys_clk) disable iff (!rst_n)
    1'b1 |-> (!data_hold && !clk_hold));

  assert_change_on_boundary_R8: assert property (@(posedge sys_clk) disable iff (!rst_n)
    ((error != $past(error)) && (slave == $past(slave))) |-> (icnt == 0 || ocnt == 0));
endmodule

bind clkcont_monitor clkcont_monitor_chk #(.IN_WIN(IN_WIN), .OUT_WIN(OUT_WIN)) u_chk (
  .sys_clk(sys_clk), .rst_n(rst_n), .slave(slave),
  .error(error), .data_hold(data_hold), .clk_hold(clk_hold)
);

// File: tb/clkcont_monitor_tb.sv
module clkcont_monitor_tb;
  localparam int CLK_P   = 10;
  localparam int IN_WIN  = 1024;
  localparam int OUT_WIN = 128;
  localparam int CNT_W   = 16;

  typedef struct packed {
    logic [3:0] stop;
    logic       slave;
    logic       exp_err;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{4'b0001, 1'b1, 1'b1, 4'd3},   // R3 frame in
    '{4'b0010, 1'b1, 1'b1, 4'd3},   // R3 bit in
    '{4'b0100, 1'b1, 1'b1, 4'd4},   // R4 frame out
    '{4'b1000, 1'b1, 1'b1, 4'd4},   // R4 bit out
    '{4'b0100, 1'b0, 1'b0, 4'd5},   // R5 frame out ignored
    '{4'b1000, 1'b0, 1'b0, 4'd5},   // R5 bit out ignored
    '{4'b0010, 1'b0, 1'b1, 4'd3}    // R3 in master mode
  };

  logic rst_n = 1'b0, sys_clk = 1'b0, slave = 1'b0;
  logic in_lr = 1'b0, in_bit = 1'b0, out_lr = 1'b0, out_bit = 1'b0;
  logic [3:0] run = 4'hF;
  logic [CNT_W-1:0] e_il = 32, e_ib = 256, e_ol = 4, e_ob = 32;
  logic error, data_hold, clk_hold;
  int n_run = 0, n_fail = 0, cyc = 0, took = 0;
  logic seen;

  clkcont_monitor #(.IN_WIN(IN_WIN), .OUT_WIN(OUT_WIN), .CNT_W(CNT_W)) u_dut (
    .rst_n(rst_n), .sys_clk(sys_clk), .in_lr(in_lr), .in_bit(in_bit),
    .out_lr(out_lr), .out_bit(out_bit), .slave(slave),
    .exp_in_lr(e_il), .exp_in_bit(e_ib), .exp_out_lr(e_ol), .exp_out_bit(e_ob),
    .error(error), .data_hold(data_hold), .clk_hold(clk_hold)
  );

  always #(CLK_P/2) sys_clk = ~sys_clk;
  always begin #(CLK_P*16); if (run[0]) in_lr   = ~in_lr;   end
  always begin #(CLK_P*2);  if (run[1]) in_bit  = ~in_bit;  end
  always begin #(CLK_P*16); if (run[2]) out_lr  = ~out_lr;  end
  always begin #(CLK_P*2);  if (run[3]) out_bit = ~out_bit; end
  always @(posedge sys_clk) if (rst_n) cyc <= cyc + 1;

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_level(input logic lvl, input int lim, output int t);
    t = -1;
    for (int i = 1; i <= lim; i++) begin
      @(negedge sys_clk);
      if (error === lvl) begin t = i; break; end
    end
  endtask

  task automatic stays_low(input int n, output logic s);
    s = 1'b0;
    repeat (n) begin
      @(negedge sys_clk);
      if (error !== 1'b0) s = 1'b1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge sys_clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge sys_clk);
    check(error === 1'b0, "R1", "error in reset", error, 0);
    check(data_hold === 1'b1, "R1", "data_hold in reset", data_hold, 1);
    check(clk_hold === 1'b1, "R2", "clk_hold reset master", clk_hold, 1);
    slave = 1'b1;
    #1 check(clk_hold === 1'b0, "R2", "clk_hold reset slave", clk_hold, 0);
    @(negedge sys_clk);
    rst_n = 1'b1;
    #1;
    check(data_hold === 1'b0, "R1", "data_hold after release", data_hold, 0);
    check(clk_hold === 1'b0, "R2", "clk_hold after release", clk_hold, 0);
    stays_low(3*IN_WIN, seen);
    check(!seen, "R3", "no error with clocks running", seen, 0);

    for (int v = 0; v < 7; v++) begin
      automatic int win = (VEC[v].stop[1:0] != 2'b00) ? IN_WIN : OUT_WIN;
      automatic int lim = 2*win + 8;
      automatic string rq = $sformatf("R%0d", VEC[v].req);
      slave = VEC[v].slave;
      repeat (IN_WIN) @(negedge sys_clk);
      run = ~VEC[v].stop;
      if (VEC[v].exp_err) begin
        wait_level(1'b1, lim, took);
        check(took > 0, rq, $sformatf("vec %0d rise latency", v), took, lim);
        check(cyc % OUT_WIN == 0, "R8", "rise on window edge", cyc % OUT_WIN, 0);
        run = 4'hF;
        wait_level(1'b0, lim, took);
        check(took > 0, "R7", $sformatf("vec %0d clear latency", v), took, lim);
        check(cyc % OUT_WIN == 0, "R8", "clear on window edge", cyc % OUT_WIN, 0);
      end else begin
        stays_low(2*IN_WIN + 8, seen);
        check(!seen, rq, $sformatf("vec %0d ignored", v), seen, 0);
        run = 4'hF;
      end
      repeat (IN_WIN) @(negedge sys_clk);
    end

    slave = 1'b1;
    repeat (IN_WIN) @(negedge sys_clk);
    e_ib = 257;
    stays_low(3*IN_WIN, seen);
    check(!seen, "R6", "in bit count off by +1 accepted", seen, 0);
    e_ib = 258;
    wait_level(1'b1, 2*IN_WIN + 8, took);
    check(took > 0, "R6", "in bit count off by +2 flagged", took, 2*IN_WIN + 8);
    e_ib = 256;
    wait_level(1'b0, 2*IN_WIN + 8, took);
    check(took > 0, "R7", "clear after count restored", took, 2*IN_WIN + 8);
    e_ol = 3;
    stays_low(3*OUT_WIN, seen);
    check(!seen, "R6", "out frame count off by -1 accepted", seen, 0);
    e_ol = 2;
    wait_level(1'b1, 2*OUT_WIN + 8, took);
    check(took > 0, "R6", "out frame count off by -2 flagged", took, 2*OUT_WIN + 8);
    check(cyc % OUT_WIN == 0, "R8", "rise on window edge", cyc % OUT_WIN, 0);
    e_ol = 4;
    wait_level(1'b0, 2*OUT_WIN + 8, took);
    check(took > 0, "R7", "clear after out count restored", took, 2*OUT_WIN + 8);

    e_ib = 300;
    wait_level(1'b1, 2*IN_WIN + 8, took);
    check(took > 0, "R6", "large mismatch flagged", took, 2*IN_WIN + 8);
    rst_n = 1'b0;
    #1;
    check(error === 1'b0, "R1", "reset clears error", error, 0);
    check(data_hold === 1'b1, "R1", "data_hold on reassert", data_hold, 1);
    check(clk_hold === 1'b0, "R2", "no clk_hold in slave", clk_hold, 0);
    slave = 1'b0;
    #1 check(clk_hold === 1'b1, "R2", "clk_hold in master reset", clk_hold, 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule